// File: doc/BRIEF.md
# Write-One-Action GPIO Bank

This block is a small bank of general-purpose pins behind a single 32-bit register. Software never writes a pin's output level or direction as a value. It writes strobes. For every pin there is a pair of bits that pulls the stored output level low or high, and a second pair that turns the pin into an output or back into an input. A bit written as 0 does nothing. Two agents that each want to move a different pin can therefore write at the same time without reading the register first and without a lock.

A read returns the level of each pin, taken from a two-stage synchronizer on the pad input, in the odd bit of that pin's pair. Every other read bit is 0. A pin in output mode reads back its pad level, not the stored output bit. The bank is built with eight pins or with four pins. In the narrower build, the action bits of the missing pins are ignored.

Each pin's direction is a two-state machine with states PIN_IN and PIN_OUT. Reset places it in PIN_IN. The transition GO_OUT, from PIN_IN to PIN_OUT, is taken on a write whose make-output bit for the pin is 1 and whose make-input bit for the pin is 0. The transition GO_IN, from PIN_OUT to PIN_IN, is taken on any write whose make-input bit for the pin is 1. In every other case the state holds.

Top module: `wsgpio_bank`

## Requirements
- R1: A write with bit 2n set and bit 2n+1 clear makes pad_out[n] 0 from the next clock edge on.
- R2: A write with bit 2n+1 set makes pad_out[n] 1 from the next clock edge on.
- R3: When bits 2n and 2n+1 are both 1 in the same write, pad_out[n] becomes 1.
- R4: A write with bit 16+2n set and bit 17+2n clear makes pad_oe[n] 1 from the next clock edge on.
- R5: A write with bit 17+2n set makes pad_oe[n] 0 from the next clock edge on, including when bit 16+2n is also set.
- R6: Bits written as 0 leave every pin's level and direction unchanged. A cycle with wr_en low changes nothing, whatever wr_data holds.
- R7: With ACTIVE_PINS = 4, the action bits of pins 4 to 7 are ignored. pad_out[7:4], pad_oe[7:4] and the read bits of those pins stay 0.
- R8: rd_data bit 2n+1 equals pad_in[n] as sampled two clock edges earlier. Every even bit, and every bit from 16 upward, reads 0.
- R9: A pin in output mode reads its pad_in level, even when that level differs from pad_out.
- R10: After reset, pad_out and pad_oe are all 0 and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write-one action bits |
| rd_data | output | 32 | Synchronized pin levels at the odd bits 2n+1 |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Stored output level per pin |
| pad_oe | output | 8 | Output enable per pin, 1 means output |

## Verification
The bench goes after the conflicting-bit writes. When both level bits of a pin are written as 1, the set must win. When both direction bits are written as 1, input must win. A design with either priority reversed leaves the pin low, or leaves it driving. Writes of zeros, and writes that carry a full pattern while the strobe is low, must leave every pin alone. A design that loaded values instead of acting on strobes would clear the neighbouring pins. The read path is checked for the two-edge latency and for the rule that pad level beats stored level on output pins; a missing synchronizer stage or a loop back of pad_out would show up there. A four-pin instance is given action bits for all eight pins, to catch decode that leaks into the absent pins.

// File: rtl/wsgpio_pkg.sv
package wsgpio_pkg;
    localparam int REG_W    = 32;
    localparam int MAX_PINS = 8;
    localparam int DIR_BASE = 16;

    typedef enum logic {
        PIN_IN  = 1'b0,
        PIN_OUT = 1'b1
    } pin_dir_e;

    typedef struct packed {
        logic drive_lo;
        logic drive_hi;
        logic make_out;
        logic make_in;
    } pin_cmd_t;
endpackage

// File: rtl/wsgpio_sync.sv
module wsgpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_a;
    logic [WIDTH-1:0] stage_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_a <= '0;
            stage_b <= '0;
        end else begin
            stage_a <= async_in;
            stage_b <= stage_a;
        end
    end

    assign sync_out = stage_b;
endmodule

// File: rtl/wsgpio_pin.sv
module wsgpio_pin
    import wsgpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  pin_cmd_t cmd,
    output logic     pad_out,
    output logic     pad_oe
);
    pin_dir_e dir_q;
    pin_dir_e dir_d;
    logic     level_q;

    // Direction state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= PIN_IN;
        else        dir_q <= dir_d;
    end

    // Transitions GO_OUT and GO_IN; make-input has priority
    always_comb begin
        dir_d = dir_q;
        unique case (dir_q)
            PIN_IN:  if (cmd_valid && cmd.make_out && !cmd.make_in) dir_d = PIN_OUT;
            PIN_OUT: if (cmd_valid && cmd.make_in)                  dir_d = PIN_IN;
            default: dir_d = PIN_IN;
        endcase
    end

    // Output level; drive-high has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          level_q <= 1'b0;
        else if (cmd_valid && cmd.drive_hi)  level_q <= 1'b1;
        else if (cmd_valid && cmd.drive_lo)  level_q <= 1'b0;
    end

    // Outputs
    always_comb begin
        pad_oe  = (dir_q == PIN_OUT);
        pad_out = level_q;
    end
endmodule

// File: rtl/wsgpio_bank.sv
module wsgpio_bank
    import wsgpio_pkg::*;
#(
    parameter int ACTIVE_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic [MAX_PINS-1:0] pad_in,
    output logic [MAX_PINS-1:0] pad_out,
    output logic [MAX_PINS-1:0] pad_oe
);
    localparam int NUSED = (ACTIVE_PINS > MAX_PINS) ? MAX_PINS : ACTIVE_PINS;

    logic [MAX_PINS-1:0] level_sync;

    wsgpio_sync #(.WIDTH(MAX_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (level_sync)
    );

    for (genvar p = 0; p < MAX_PINS; p++) begin : g_pin
        if (p < NUSED) begin : g_used
            pin_cmd_t cmd;
            assign cmd.drive_lo = wr_data[2*p];
            assign cmd.drive_hi = wr_data[2*p+1];
            assign cmd.make_out = wr_data[DIR_BASE+2*p];
            assign cmd.make_in  = wr_data[DIR_BASE+2*p+1];

            wsgpio_pin u_pin (
                .clk       (clk),
                .rst_n     (rst_n),
                .cmd_valid (wr_en),
                .cmd       (cmd),
                .pad_out   (pad_out[p]),
                .pad_oe    (pad_oe[p])
            );

            assign rd_data[2*p]              = 1'b0;
            assign rd_data[2*p+1]            = level_sync[p];
            assign rd_data[DIR_BASE+2*p]     = 1'b0;
            assign rd_data[DIR_BASE+2*p+1]   = 1'b0;
        end else begin : g_absent
            assign pad_out[p]              = 1'b0;
            assign pad_oe[p]               = 1'b0;
            assign rd_data[2*p]            = 1'b0;
            assign rd_data[2*p+1]          = 1'b0;
            assign rd_data[DIR_BASE+2*p]   = 1'b0;
            assign rd_data[DIR_BASE+2*p+1] = 1'b0;
        end
    end
endmodule

// File: rtl/wsgpio_bank_chk.sv
module wsgpio_bank_chk #(
    parameter int ACTIVE_PINS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic [7:0]  pad_in,
    input logic [7:0]  pad_out,
    input logic [7:0]  pad_oe
);
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         age <= 2'd0;
        else if (age != 3)  age <= age + 2'd1;
    end

    for (genvar n = 0; n < 8; n++) begin : g_chk
        if (n < ACTIVE_PINS) begin : g_on
            // R1
            drive_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && wr_data[2*n] && !wr_data[2*n+1] |=> !pad_out[n]);
            // R2
            drive_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && wr_data[2*n+1] |=> pad_out[n]);
            // R4
            make_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && wr_data[16+2*n] && !wr_data[17+2*n] |=> pad_oe[n]);
            // R5
            make_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && wr_data[17+2*n] |=> !pad_oe[n]);
            // R8
            rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (age >= 2) |-> rd_data[2*n+1] == $past(pad_in[n], 2));
        end else begin : g_off
            // R7
            absent_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !pad_out[n] && !pad_oe[n] && !rd_data[2*n+1]);
        end
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pad_out) && $stable(pad_oe));

    // R8
    rd_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 32'hFFFF_5555) == 32'h0);
endmodule

bind wsgpio_bank wsgpio_bank_chk #(.ACTIVE_PINS(ACTIVE_PINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
);

// File: tb/wsgpio_bank_bench.sv
module wsgpio_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  pad_in = '0;
    logic [31:0] rd_w, rd_n;
    logic [7:0]  out_w, oe_w, out_n, oe_n;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wsgpio_bank #(.ACTIVE_PINS(8)) u_wsgpio_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_w), .pad_in(pad_in), .pad_out(out_w), .pad_oe(oe_w));

    wsgpio_bank #(.ACTIVE_PINS(4)) u_wsgpio_bank_narrow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_n), .pad_in(pad_in), .pad_out(out_n), .pad_oe(oe_n));

    // Behavioural reference for both widths
    logic [7:0] m_lvl [2];
    logic [7:0] m_oe  [2];
    logic [7:0] m_s1, m_s2;

    function automatic logic [31:0] exp_rd(int act);
        logic [31:0] r = '0;
        for (int n = 0; n < act; n++) r[2*n+1] = m_s2[n];
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_lvl[k] <= '0;
                m_oe[k]  <= '0;
            end
            m_s1 <= '0;
            m_s2 <= '0;
        end else begin
            m_s1 <= pad_in;
            m_s2 <= m_s1;
            for (int k = 0; k < 2; k++) begin
                for (int n = 0; n < (k == 0 ? 8 : 4); n++) begin
                    if (wr_en) begin
                        if (wr_data[2*n+1])        m_lvl[k][n] <= 1'b1;
                        else if (wr_data[2*n])     m_lvl[k][n] <= 1'b0;
                        if (wr_data[17+2*n])       m_oe[k][n]  <= 1'b0;
                        else if (wr_data[16+2*n])  m_oe[k][n]  <= 1'b1;
                    end
                end
            end
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(out_w == m_lvl[0], "R1 R2 R3 R6 level", {24'h0, out_w}, {24'h0, m_lvl[0]});
            check(oe_w  == m_oe[0],  "R4 R5 R6 direction", {24'h0, oe_w}, {24'h0, m_oe[0]});
            check(rd_w  == exp_rd(8), "R8 R9 read", rd_w, exp_rd(8));
            check(out_n == m_lvl[1], "R7 narrow level", {24'h0, out_n}, {24'h0, m_lvl[1]});
            check(oe_n  == m_oe[1],  "R7 narrow direction", {24'h0, oe_n}, {24'h0, m_oe[1]});
            check(rd_n  == exp_rd(4), "R7 narrow read", rd_n, exp_rd(4));
        end
    end

    task automatic summary();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            summary();
        end
    end

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic pads(logic [7:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] spread(logic [7:0] v, int act);
        logic [31:0] r = '0;
        for (int n = 0; n < act; n++) r[2*n+1] = v[n];
        return r;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(out_w == 0 && oe_w == 0, "R10 outputs", {16'h0, out_w, oe_w}, 32'h0);
        check(rd_w == 0, "R10 read", rd_w, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4: pin0 high and output
        wr(32'h0001_0002);
        check(out_w[0] == 1 && oe_w[0] == 1, "R2 R4 pin0", {30'h0, out_w[0], oe_w[0]}, 32'h3);
        // R3: both level bits for pin1
        wr(32'h0000_000C);
        check(out_w[1] == 1, "R3 set wins", {31'h0, out_w[1]}, 32'h1);
        // R1: pin0 low, pin1 untouched
        wr(32'h0000_0001);
        check(out_w[1:0] == 2'b10, "R1 clear", {30'h0, out_w[1:0]}, 32'h2);
        // R4 then R5 with both direction bits
        wr(32'h0004_0000);
        check(oe_w[1] == 1, "R4 pin1 out", {31'h0, oe_w[1]}, 32'h1);
        wr(32'h000C_0000);
        check(oe_w[1] == 0, "R5 input wins", {31'h0, oe_w[1]}, 32'h0);
        // R6: zero write and idle strobe
        wr(32'h0);
        check(out_w == 8'h02 && oe_w == 8'h01, "R6 zero write", {16'h0, out_w, oe_w}, 32'h0201);
        @(negedge clk);
        wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_data = '0;
        check(out_w == 8'h02 && oe_w == 8'h01, "R6 wr_en low", {16'h0, out_w, oe_w}, 32'h0201);
        // R8 synchronized read
        pads(8'hA5);
        check(rd_w == spread(8'hA5, 8), "R8 read pattern", rd_w, spread(8'hA5, 8));
        pads(8'h5A);
        check(rd_w == spread(8'h5A, 8), "R8 read pattern2", rd_w, spread(8'h5A, 8));
        // R9: pin0 output driving high, pad low
        wr(32'h0001_0002);
        pads(8'h00);
        check(out_w[0] == 1 && rd_w[1] == 0, "R9 pad level", {30'h0, out_w[0], rd_w[1]}, 32'h2);
        // R7: narrow instance with all pins commanded
        wr(32'h5555_AAAA);
        check(out_n == 8'h0F && oe_n == 8'h0F, "R7 narrow ignore", {16'h0, out_n, oe_n}, 32'h0F0F);
        pads(8'hFF);
        check(rd_n == 32'h0000_00AA, "R7 narrow read", rd_n, 32'h0000_00AA);
        check(out_w == 8'hFF && oe_w == 8'hFF, "R2 R4 all pins", {16'h0, out_w, oe_w}, 32'hFFFF);

        repeat (2) @(negedge clk);
        summary();
    end
endmodule